// File: doc/BRIEF.md
# Multi-Threshold Hit Frame Memory

This block sits behind a multi-channel front end in which every channel has three discriminators: low, medium and high. While the acquisition window is open, each bunch-crossing cycle turns each channel's unmasked discriminator outputs into a 2-bit severity code. In any cycle where at least one unmasked trigger is active, the block writes one frame to an on-chip memory. A frame holds the codes of all channels, the current bunch-crossing number and a fixed header. Three chip-level trigger outputs, one per threshold level, are also available to the surrounding logic.

After the window closes, a start pulse begins readout. The stored frames leave on a single serial line, most recent frame first and most significant bit first. A data-valid signal stays high for the whole transfer. When the last bit has been sent, the memory is empty and ready for the next window. A write happens only when a real hit is stored, so no empty frame is ever written. Once every slot is used, further hits are dropped.

Top module: `hitframe_store`

## Requirements
- R1: A channel's code is `11` if its unmasked high trigger is active. Otherwise it is `10` if its unmasked medium trigger is active, `01` if its unmasked low trigger is active, and `00` if none is active. Channel i's code is stored at frame bits [2i+1:2i].
- R2: A mask bit set to 1 removes that channel's trigger at that level from the code, from the chip-level trigger and from the store decision.
- R3: `chip_trig` bit 0, 1 and 2 is the OR over all channels of the unmasked low, medium and high triggers, with no register in the path.
- R4: A frame is written on a rising clock edge only when all of these hold at that edge: `acq_en` is 1, `chip_trig` is non-zero, the memory is not full, no readout is in progress, and no readout is starting. No other cycle writes a frame.
- R5: Frame layout from the MSB down: header (value `HDR_VAL`, `HDR_W` bits), then the bunch-crossing number that `bx_id` shows in the storing cycle, then the channel codes.
- R6: `bx_id` goes to 0 on reset and then increments by one on every clock, wrapping at 2^`BCID_W`.
- R7: `full` is 1 exactly while `DEPTH` frames are held. Hits that arrive while the memory is full are dropped.
- R8: If `rd_start` is 1 at an edge with no readout running and at least one frame held, then `sdv` is 1 from that edge for frames×FW cycles. During that time `sdata` carries the frames newest first, MSB first, one bit per clock. `rd_start` with an empty memory has no effect.
- R9: When a readout ends, the memory holds zero frames, `full` is 0, and `sdata` is 0 whenever `sdv` is 0.
- R10: After reset, `sdv`, `sdata`, `full` and `bx_id` are 0 and no frame is held.
- R11: While a readout runs, both hits and `rd_start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition window open |
| trig_lo | input | NCH | Low-threshold discriminator per channel |
| trig_mid | input | NCH | Medium-threshold discriminator per channel |
| trig_hi | input | NCH | High-threshold discriminator per channel |
| mask_lo | input | NCH | Per-channel low-level mask, 1 = masked |
| mask_mid | input | NCH | Per-channel medium-level mask, 1 = masked |
| mask_hi | input | NCH | Per-channel high-level mask, 1 = masked |
| rd_start | input | 1 | Request to begin serial readout |
| chip_trig | output | 3 | Chip-level trigger per level (low, mid, high) |
| bx_id | output | BCID_W | Bunch-crossing counter |
| full | output | 1 | All frame slots are used |
| sdata | output | 1 | Serial readout data |
| sdv | output | 1 | Serial data valid |

## Verification
The bench builds the block with four channels, a four-frame memory, an 8-bit bunch-crossing counter and an 8-bit header, so each frame is 24 bits. At that size, a handful of hits fills the memory. Overflow drops, complete newest-first readouts and wrap of the crossing counter all occur within a few thousand cycles. Four channels are still enough to drive every code value on separate channels in the same cycle and to mask each level on its own.

// File: rtl/hf_pkg.sv
package hf_pkg;

    typedef enum logic [1:0] {
        HIT_NONE = 2'b00,
        HIT_LOW  = 2'b01,
        HIT_MID  = 2'b10,
        HIT_HIGH = 2'b11
    } hit_code_e;

    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_e;

    typedef struct packed {
        logic hi;
        logic mid;
        logic lo;
    } lvl_hits_t;

    // Highest active level wins.
    function automatic hit_code_e hit_encode(input lvl_hits_t h);
        if (h.hi)       return HIT_HIGH;
        else if (h.mid) return HIT_MID;
        else if (h.lo)  return HIT_LOW;
        else            return HIT_NONE;
    endfunction

endpackage

// File: rtl/hf_hit_encoder.sv
module hf_hit_encoder
    import hf_pkg::*;
#(
    parameter int NCH = 64
) (
    input  logic [NCH-1:0]   trig_lo,
    input  logic [NCH-1:0]   trig_mid,
    input  logic [NCH-1:0]   trig_hi,
    input  logic [NCH-1:0]   mask_lo,
    input  logic [NCH-1:0]   mask_mid,
    input  logic [NCH-1:0]   mask_hi,
    output logic [2*NCH-1:0] codes,
    output lvl_hits_t        chip_lvl
);
    logic [NCH-1:0] lo_q, mid_q, hi_q;

    assign lo_q  = trig_lo  & ~mask_lo;
    assign mid_q = trig_mid & ~mask_mid;
    assign hi_q  = trig_hi  & ~mask_hi;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        lvl_hits_t h;
        assign h.lo  = lo_q[ch];
        assign h.mid = mid_q[ch];
        assign h.hi  = hi_q[ch];
        assign codes[2*ch +: 2] = hit_encode(h);
    end

    assign chip_lvl.lo  = |lo_q;
    assign chip_lvl.mid = |mid_q;
    assign chip_lvl.hi  = |hi_q;
endmodule

// File: rtl/hf_frame_ram.sv
module hf_frame_ram #(
    parameter int DEPTH = 128,
    parameter int FW    = 160,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [FW-1:0] wdata,
    input  logic          clr,
    input  logic [AW-1:0] rd_addr,
    output logic [FW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [FW-1:0] mem [DEPTH];
    logic          do_wr;

    assign full    = (count == CW'(DEPTH));
    assign do_wr   = we && !full;
    assign rd_data = mem[rd_addr];

    // The fill count is the write pointer; only accepted writes move it.
    always_ff @(posedge clk) begin
        if (do_wr) mem[AW'(count)] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  count <= '0;
        else if (do_wr)  count <= count + 1'b1;
    end
endmodule

// File: rtl/hf_readout_ser.sv
module hf_readout_ser
    import hf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int FW    = 160,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic [FW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          accept,
    output logic          done_clr,
    output logic          sdv,
    output logic          sdata
);
    ser_state_e    state;
    logic [FW-1:0] shreg;
    logic [AW-1:0] fidx;
    logic [BW-1:0] bitc;
    logic          last_bit;

    assign sdv      = (state == SER_SHIFT);
    assign accept   = (state == SER_IDLE) && start && (count != '0);
    assign last_bit = (bitc == BW'(FW - 1));
    assign done_clr = sdv && last_bit && (fidx == '0);
    assign rd_addr  = sdv ? (fidx - 1'b1) : AW'(count - 1'b1);
    assign sdata    = shreg[FW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            shreg <= '0;
            fidx  <= '0;
            bitc  <= '0;
        end else begin
            case (state)
                SER_IDLE: begin
                    if (accept) begin
                        state <= SER_SHIFT;
                        shreg <= rd_data;
                        fidx  <= AW'(count - 1'b1);
                        bitc  <= '0;
                    end
                end
                default: begin
                    if (last_bit) begin
                        bitc <= '0;
                        if (fidx == '0) begin
                            state <= SER_IDLE;
                            shreg <= '0;
                        end else begin
                            fidx  <= fidx - 1'b1;
                            shreg <= rd_data;
                        end
                    end else begin
                        bitc  <= bitc + 1'b1;
                        shreg <= {shreg[FW-2:0], 1'b0};
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hitframe_store.sv
module hitframe_store
    import hf_pkg::*;
#(
    parameter int          NCH     = 64,
    parameter int          DEPTH   = 128,
    parameter int          BCID_W  = 24,
    parameter int          HDR_W   = 8,
    parameter logic [HDR_W-1:0] HDR_VAL = 8'hA5,
    localparam int         FW      = 2*NCH + BCID_W + HDR_W,
    localparam int         AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int         CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_en,
    input  logic [NCH-1:0]    trig_lo,
    input  logic [NCH-1:0]    trig_mid,
    input  logic [NCH-1:0]    trig_hi,
    input  logic [NCH-1:0]    mask_lo,
    input  logic [NCH-1:0]    mask_mid,
    input  logic [NCH-1:0]    mask_hi,
    input  logic              rd_start,
    output logic [2:0]        chip_trig,
    output logic [BCID_W-1:0] bx_id,
    output logic              full,
    output logic              sdata,
    output logic              sdv
);
    logic [2*NCH-1:0] codes;
    lvl_hits_t        chip_lvl;
    logic [FW-1:0]    wdata, rd_data;
    logic [AW-1:0]    rd_addr;
    logic [CW-1:0]    ram_count;
    logic             accept, done_clr, store_we;

    hf_hit_encoder #(.NCH(NCH)) u_enc (
        .trig_lo  (trig_lo),
        .trig_mid (trig_mid),
        .trig_hi  (trig_hi),
        .mask_lo  (mask_lo),
        .mask_mid (mask_mid),
        .mask_hi  (mask_hi),
        .codes    (codes),
        .chip_lvl (chip_lvl)
    );

    assign chip_trig = {chip_lvl.hi, chip_lvl.mid, chip_lvl.lo};

    always_ff @(posedge clk) begin
        if (rst) bx_id <= '0;
        else     bx_id <= bx_id + 1'b1;
    end

    assign wdata    = {HDR_VAL, bx_id, codes};
    assign store_we = acq_en && (chip_trig != 3'b000) && !sdv && !accept;

    hf_frame_ram #(.DEPTH(DEPTH), .FW(FW)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .we      (store_we),
        .wdata   (wdata),
        .clr     (done_clr),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .count   (ram_count),
        .full    (full)
    );

    hf_readout_ser #(.DEPTH(DEPTH), .FW(FW)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .start    (rd_start),
        .count    (ram_count),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .accept   (accept),
        .done_clr (done_clr),
        .sdv      (sdv),
        .sdata    (sdata)
    );
endmodule

// File: rtl/hf_store_chk.sv
module hf_store_chk #(
    parameter int  DEPTH  = 128,
    parameter int  BCID_W = 24,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              acq_en,
    input logic [2:0]        chip_trig,
    input logic [BCID_W-1:0] bx_id,
    input logic              full,
    input logic              sdv,
    input logic              sdata,
    input logic [CW-1:0]     count
);
    AST_BCID_STEP: assert property (@(posedge clk) disable iff (rst)
        sdv || !sdv |=> bx_id == BCID_W'($past(bx_id) + 1'b1)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        full && !sdv |=> full && count == CW'(DEPTH)); // R7

    AST_NO_DUMMY: assert property (@(posedge clk) disable iff (rst)
        !sdv && !(acq_en && chip_trig != 3'b000) |=> $stable(count)); // R4

    AST_READ_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        sdv |-> count != '0); // R8

    AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(sdv) |-> count == '0 && !full && !sdata); // R9

    AST_FROZEN_IN_READ: assert property (@(posedge clk) disable iff (rst)
        sdv |=> count == $past(count) || count == '0); // R11
endmodule

bind hitframe_store hf_store_chk #(.DEPTH(DEPTH), .BCID_W(BCID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acq_en    (acq_en),
    .chip_trig (chip_trig),
    .bx_id     (bx_id),
    .full      (full),
    .sdv       (sdv),
    .sdata     (sdata),
    .count     (ram_count)
);

// File: tb/tb_hitframe_store.sv
module tb_hitframe_store;
    localparam int NCH = 4, DEPTH = 4, BCID_W = 8, HDR_W = 8;
    localparam logic [HDR_W-1:0] HDR = 8'hA5;
    localparam int FW = 2*NCH + BCID_W + HDR_W;

    logic clk = 1'b0, rst = 1'b1, acq_en = 1'b0, rd_start = 1'b0;
    logic [NCH-1:0] trig_lo = '0, trig_mid = '0, trig_hi = '0;
    logic [NCH-1:0] mask_lo = '0, mask_mid = '0, mask_hi = '0;
    logic [2:0] chip_trig;
    logic [BCID_W-1:0] bx_id;
    logic full, sdata, sdv;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;  // 250 MHz

    hitframe_store #(.NCH(NCH), .DEPTH(DEPTH), .BCID_W(BCID_W),
                     .HDR_W(HDR_W), .HDR_VAL(HDR)) dut (.*);

    // ---------------- reference model ----------------
    logic [FW-1:0] q[$];
    int m_bx = 0, m_bit = 0, m_fidx = 0;
    bit m_busy = 0;

    function automatic logic [2:0] levels();
        return {|(trig_hi & ~mask_hi), |(trig_mid & ~mask_mid), |(trig_lo & ~mask_lo)};
    endfunction

    function automatic logic [FW-1:0] mkframe(int bx);
        logic [FW-1:0] f = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            bit l = trig_lo[ch] & ~mask_lo[ch];
            bit m = trig_mid[ch] & ~mask_mid[ch];
            bit h = trig_hi[ch] & ~mask_hi[ch];
            f[2*ch +: 2] = h ? 2'd3 : m ? 2'd2 : l ? 2'd1 : 2'd0;
        end
        f[2*NCH +: BCID_W] = BCID_W'(bx);
        f[FW-1 -: HDR_W] = HDR;
        return f;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_bx = 0; m_busy = 0; m_bit = 0; m_fidx = 0;
        end else begin
            if (m_busy) begin                       // R11: nothing else acts
                m_bit++;
                if (m_bit == FW) begin
                    m_bit = 0;
                    if (m_fidx == 0) begin m_busy = 0; q.delete(); end
                    else m_fidx--;
                end
            end else if (rd_start && q.size() > 0) begin
                m_busy = 1; m_fidx = q.size() - 1; m_bit = 0;
            end else if (acq_en && levels() != 3'b000 && q.size() < DEPTH) begin
                q.push_back(mkframe(m_bx));
            end
            m_bx = (m_bx + 1) % (1 << BCID_W);
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, 1 ns after the edge.
    always begin
        @(posedge clk); #1;
        if (!finished) begin
            logic e_sd;
            e_sd = m_busy ? q[m_fidx][FW-1-m_bit] : 1'b0;
            cmp(rst ? "R10 sdv" : "R8 sdv", 32'(sdv), 32'(m_busy));
            cmp(rst ? "R10 sdata" : "R1 R2 R4 R5 R8 sdata", 32'(sdata), 32'(e_sd));
            cmp(rst ? "R10 full" : "R7 full", 32'(full), 32'(q.size() == DEPTH));
            cmp(rst ? "R10 bx_id" : "R6 bx_id", 32'(bx_id), 32'(m_bx));
            cmp("R2 R3 chip_trig", 32'(chip_trig), 32'(levels()));
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_trig(logic [NCH-1:0] l, logic [NCH-1:0] m, logic [NCH-1:0] h);
        trig_lo = l; trig_mid = m; trig_hi = h;
    endtask

    task automatic pulse_read();
        rd_start = 1'b1; step(); rd_start = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (sdv && guard < 10000) begin step(); guard++; end
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        // R1: every code on its own channel, then high-only (11) and mid-only (10)
        acq_en = 1'b1;
        set_trig(4'b0111, 4'b0110, 4'b0100); step();
        set_trig(4'b0000, 4'b0000, 4'b1000); step();
        set_trig('0, '0, '0); step(5);        // R4: idle cycles write nothing
        set_trig(4'b0000, 4'b0010, 4'b0000); step();
        // R2: masked trigger must not store
        mask_lo = 4'b1111; set_trig(4'b1111, '0, '0); step(2);
        mask_lo = '0;
        set_trig(4'b1001, 4'b0001, 4'b0000); step();
        // R7: memory now full, extra hits dropped
        set_trig(4'b1111, 4'b1111, 4'b1111); step(3);
        set_trig('0, '0, '0); acq_en = 1'b0;
        step();
        pulse_read();
        // R11: hits and restart during readout ignored
        acq_en = 1'b1; set_trig(4'b0101, '0, '0); rd_start = 1'b1;
        wait_idle();
        set_trig('0, '0, '0); acq_en = 1'b0; rd_start = 1'b0;
        step();
        cmp("R9 full after read", 32'(full), 32'd0);
        cmp("R9 sdata idle", 32'(sdata), 32'd0);
        pulse_read();                         // empty: no effect
        step();
        cmp("R11 R8 empty read", 32'(sdv), 32'd0);

        // Random phase: masks, sparse hits, reads
        for (int it = 0; it < 40; it++) begin
            mask_lo = NCH'($urandom); mask_mid = NCH'($urandom); mask_hi = NCH'($urandom);
            acq_en = 1'b1;
            for (int k = 0; k < 30; k++) begin
                if ($urandom_range(0, 3) == 0)
                    set_trig(NCH'($urandom), NCH'($urandom), NCH'($urandom));
                else
                    set_trig('0, '0, '0);
                acq_en = ($urandom_range(0, 7) != 0);
                step();
            end
            set_trig('0, '0, '0);
            acq_en = ($urandom_range(0, 1) == 0);
            pulse_read();
            wait_idle();
            step(2);
        end
        // R6: run long enough for the counter to wrap
        acq_en = 1'b0;
        step(300);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule